// File: doc/BRIEF.md
# Lockable Index/Data Configuration Register File

This block is a byte-wide configuration register file for a PC chipset. Software reaches it through two I/O ports. A write to the index port selects one of 256 byte registers. A read or write of the data port then reaches the selected register. A two-state lock machine guards every store into the array. Software must write a fixed key byte to a dedicated key index before any register can change. Writing anything else to that index closes the file again.

Three register fields drive outputs to the rest of the chip. A segment-enable register and an attribute register together set the read and write routing of eight 32 KB shadow segments. Segment i starts at address 0xC0000 + i×0x8000, and segment 6 is the system firmware window. One bit of a cache-control register drives the external cache enable.

The lock machine has two states. LK_SHUT is the reset state, and in it stores are refused. LK_OPEN accepts stores. Three transitions are named:
- UNLOCK goes from LK_SHUT to LK_OPEN when the key byte is written to the key index.
- RELOCK goes from LK_OPEN to LK_SHUT when any other byte is written to the key index.
- HOLD covers every other cycle and leaves the state unchanged.

Top module: `lockcfg_top`

## Requirements
- R1: A write strobe with address 0x22 loads the data byte into the index register. The index keeps its value until the next such write.
- R2: After reset the file is in LK_SHUT. In LK_SHUT, a data-port write (address 0x23) to any index other than 0x03 leaves the register array unchanged.
- R3: A data-port write of 0xC5 while the index is 0x03 moves the machine to LK_OPEN (UNLOCK). The byte 0xC5 is stored in register 0x03.
- R4: A data-port write of any value other than 0xC5 while the index is 0x03 moves the machine to LK_SHUT (RELOCK). That value is not stored.
- R5: In LK_OPEN, a data-port write stores the byte in the register selected by the index.
- R6: With the read strobe high and address 0x23, read data equals the selected register. In every other case read data is 0xFF.
- R7: Segment i's read-internal flag is bit i of register 0x13 AND bit 0 of register 0x14. Segment 6 is the firmware window.
- R8: Segment i's write-internal flag is bit i of register 0x13 AND bit 1 of register 0x14.
- R9: The cache enable output equals bit 1 of register 0x18.
- R10: Every register, the index and the lock state reset to zero / LK_SHUT.
- R11: Write strobes at addresses other than 0x22 and 0x23 change neither the index nor any register.
- R12: The segment flags and the cache enable reflect a store in the first cycle after the clock edge that stored it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, sampled on the rising edge |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (0xFF when not selected) |
| seg_rd_int | output | 8 | Per-segment read-internal flags |
| seg_wr_int | output | 8 | Per-segment write-internal flags |
| ext_cache_en | output | 1 | External cache enable |

## Verification
The assertions check the following on every cycle:
- the index stays stable without an index-port write;
- no store happens in LK_SHUT;
- UNLOCK and RELOCK follow key-index writes;
- read data idles at 0xFF;
- the segment flags never exceed the enable and attribute bits;
- the cache output follows a store to its register.

Only the bench scenarios can show the data-dependent outcomes:
- that a refused write really leaves the value readable afterwards;
- that the key byte lands in register 0x03 while a relocking byte does not;
- that stray addresses are ignored;
- that every register reads back zero after reset.

// File: rtl/lockcfg_pkg.sv
package lockcfg_pkg;

    typedef enum logic {
        LK_SHUT = 1'b0,
        LK_OPEN = 1'b1
    } lock_state_e;

    localparam int unsigned DEF_ADDR_W = 16;
    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_NUM_SEG = 8;

endpackage

// File: rtl/lockcfg_decode.sv
module lockcfg_decode #(
    parameter int unsigned ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IDX_PORT = 16'h0022,
    parameter logic [ADDR_W-1:0] DAT_PORT = 16'h0023
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic              idx_wr,
    output logic              dat_wr,
    output logic              dat_rd
);
    logic hit_idx;
    logic hit_dat;

    always_comb begin
        hit_idx = (io_addr == IDX_PORT);
        hit_dat = (io_addr == DAT_PORT);
        idx_wr  = io_wr & hit_idx;
        dat_wr  = io_wr & hit_dat;
        dat_rd  = io_rd & hit_dat;
    end
endmodule

// File: rtl/lockcfg_lock.sv
module lockcfg_lock
    import lockcfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_wr,
    input  logic key_ok,
    output logic unlocked,
    output logic write_allow
);
    lock_state_e state_q;
    lock_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_SHUT;
        else        state_q <= state_d;
    end

    // transitions: UNLOCK, RELOCK, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_SHUT: if (key_wr && key_ok)  state_d = LK_OPEN;
            LK_OPEN: if (key_wr && !key_ok) state_d = LK_SHUT;
            default: state_d = LK_SHUT;
        endcase
    end

    // outputs: a store is allowed when the cycle ends in LK_OPEN
    always_comb begin
        unlocked    = (state_q == LK_OPEN);
        write_allow = (state_d == LK_OPEN);
    end
endmodule

// File: rtl/lockcfg_regs.sv
module lockcfg_regs #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned NUM_SEG   = 8,
    parameter logic [DATA_W-1:0] SEG_REG   = 8'h13,
    parameter logic [DATA_W-1:0] ATTR_REG  = 8'h14,
    parameter logic [DATA_W-1:0] CACHE_REG = 8'h18,
    parameter int unsigned RD_BIT    = 0,
    parameter int unsigned WR_BIT    = 1,
    parameter int unsigned CACHE_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] idx_q,
    output logic [DATA_W-1:0] sel_data,
    output logic [NUM_SEG-1:0] seg_en,
    output logic              attr_rd,
    output logic              attr_wr,
    output logic              cache_bit
);
    localparam int unsigned NUM_REGS = 1 << DATA_W;

    logic [DATA_W-1:0] mem [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_wr) idx_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_REGS; k++) mem[k] <= '0;
        end else if (reg_wen) begin
            mem[idx_q] <= wdata;
        end
    end

    always_comb begin
        sel_data  = mem[idx_q];
        seg_en    = mem[SEG_REG][NUM_SEG-1:0];
        attr_rd   = mem[ATTR_REG][RD_BIT];
        attr_wr   = mem[ATTR_REG][WR_BIT];
        cache_bit = mem[CACHE_REG][CACHE_BIT];
    end
endmodule

// File: rtl/lockcfg_shadow.sv
module lockcfg_shadow #(
    parameter int unsigned NUM_SEG = 8
) (
    input  logic [NUM_SEG-1:0] seg_en,
    input  logic               attr_rd,
    input  logic               attr_wr,
    output logic [NUM_SEG-1:0] seg_rd_int,
    output logic [NUM_SEG-1:0] seg_wr_int
);
    // a disabled segment routes both directions to the external bus
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        assign seg_rd_int[g] = seg_en[g] & attr_rd;
        assign seg_wr_int[g] = seg_en[g] & attr_wr;
    end
endmodule

// File: rtl/lockcfg_top.sv
module lockcfg_top
    import lockcfg_pkg::*;
#(
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned DATA_W  = DEF_DATA_W,
    parameter int unsigned NUM_SEG = DEF_NUM_SEG,
    parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h0022,
    parameter logic [ADDR_W-1:0] DAT_PORT  = 16'h0023,
    parameter logic [DATA_W-1:0] LOCK_IDX  = 8'h03,
    parameter logic [DATA_W-1:0] KEY_VAL   = 8'hC5,
    parameter logic [DATA_W-1:0] SEG_REG   = 8'h13,
    parameter logic [DATA_W-1:0] ATTR_REG  = 8'h14,
    parameter logic [DATA_W-1:0] CACHE_REG = 8'h18,
    parameter int unsigned CACHE_BIT = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [DATA_W-1:0]  io_wdata,
    output logic [DATA_W-1:0]  io_rdata,
    output logic [NUM_SEG-1:0] seg_rd_int,
    output logic [NUM_SEG-1:0] seg_wr_int,
    output logic               ext_cache_en
);
    logic              idx_wr;
    logic              dat_wr;
    logic              dat_rd;
    logic              key_wr;
    logic              key_ok;
    logic              unlocked;
    logic              write_allow;
    logic              reg_wen;
    logic [DATA_W-1:0] idx_q;
    logic [DATA_W-1:0] sel_data;
    logic [NUM_SEG-1:0] seg_en;
    logic              attr_rd;
    logic              attr_wr;

    lockcfg_decode #(
        .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT)
    ) u_dec (
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .idx_wr(idx_wr), .dat_wr(dat_wr), .dat_rd(dat_rd)
    );

    assign key_wr  = dat_wr & (idx_q == LOCK_IDX);
    assign key_ok  = (io_wdata == KEY_VAL);
    assign reg_wen = dat_wr & write_allow;

    lockcfg_lock u_lock (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_ok(key_ok),
        .unlocked(unlocked), .write_allow(write_allow)
    );

    lockcfg_regs #(
        .DATA_W(DATA_W), .NUM_SEG(NUM_SEG), .SEG_REG(SEG_REG),
        .ATTR_REG(ATTR_REG), .CACHE_REG(CACHE_REG),
        .RD_BIT(0), .WR_BIT(1), .CACHE_BIT(CACHE_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .reg_wen(reg_wen),
        .wdata(io_wdata), .idx_q(idx_q), .sel_data(sel_data),
        .seg_en(seg_en), .attr_rd(attr_rd), .attr_wr(attr_wr),
        .cache_bit(ext_cache_en)
    );

    lockcfg_shadow #(.NUM_SEG(NUM_SEG)) u_shadow (
        .seg_en(seg_en), .attr_rd(attr_rd), .attr_wr(attr_wr),
        .seg_rd_int(seg_rd_int), .seg_wr_int(seg_wr_int)
    );

    assign io_rdata = dat_rd ? sel_data : '1;
endmodule

// File: rtl/lockcfg_checker.sv
module lockcfg_checker #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned NUM_SEG = 8,
    parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h0022,
    parameter logic [ADDR_W-1:0] DAT_PORT  = 16'h0023,
    parameter logic [DATA_W-1:0] LOCK_IDX  = 8'h03,
    parameter logic [DATA_W-1:0] KEY_VAL   = 8'hC5,
    parameter logic [DATA_W-1:0] CACHE_REG = 8'h18,
    parameter int unsigned CACHE_BIT = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  io_addr,
    input logic               io_wr,
    input logic               io_rd,
    input logic [DATA_W-1:0]  io_wdata,
    input logic [DATA_W-1:0]  io_rdata,
    input logic [NUM_SEG-1:0] seg_rd_int,
    input logic [NUM_SEG-1:0] seg_wr_int,
    input logic               ext_cache_en,
    input logic               unlocked,
    input logic               reg_wen,
    input logic [DATA_W-1:0]  idx_q,
    input logic [NUM_SEG-1:0] seg_en,
    input logic               attr_rd,
    input logic               attr_wr
);
    a_r1_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == IDX_PORT) |=> $stable(idx_q));
    a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == IDX_PORT) |=> idx_q == $past(io_wdata));
    a_r2_locked_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && io_wr && io_addr == DAT_PORT && idx_q != LOCK_IDX) |-> !reg_wen);
    a_r3_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == DAT_PORT && idx_q == LOCK_IDX && io_wdata == KEY_VAL) |=> unlocked);
    a_r4_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == DAT_PORT && idx_q == LOCK_IDX && io_wdata != KEY_VAL) |=> !unlocked);
    a_r4_relock_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == DAT_PORT && idx_q == LOCK_IDX && io_wdata != KEY_VAL) |-> !reg_wen);
    a_r6_idle_ff: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_addr == DAT_PORT) |-> io_rdata == {DATA_W{1'b1}});
    a_r7_rd_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_rd_int & ~seg_en) == '0);
    a_r7_rd_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_rd_int != '0) |-> attr_rd);
    a_r8_wr_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_wr_int & ~seg_en) == '0);
    a_r8_wr_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_wr_int != '0) |-> attr_wr);
    a_r9_cache_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && idx_q == CACHE_REG) |=> ext_cache_en == $past(io_wdata[CACHE_BIT]));
endmodule

bind lockcfg_top lockcfg_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEG(NUM_SEG),
    .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT), .LOCK_IDX(LOCK_IDX),
    .KEY_VAL(KEY_VAL), .CACHE_REG(CACHE_REG), .CACHE_BIT(CACHE_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .seg_rd_int(seg_rd_int), .seg_wr_int(seg_wr_int),
    .ext_cache_en(ext_cache_en), .unlocked(unlocked), .reg_wen(reg_wen),
    .idx_q(idx_q), .seg_en(seg_en), .attr_rd(attr_rd), .attr_wr(attr_wr)
);

// File: tb/test_lockcfg_top.sv
module test_lockcfg_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic [7:0]  seg_rd_int;
    logic [7:0]  seg_wr_int;
    logic        ext_cache_en;

    int checks = 0;
    int errors = 0;

    // behavioural reference model
    logic [7:0] m_mem [256];
    int         m_idx = 0;
    bit         m_locked = 1'b1;

    lockcfg_top i_lockcfg_top (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .seg_rd_int(seg_rd_int), .seg_wr_int(seg_wr_int),
        .ext_cache_en(ext_cache_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 256; k++) m_mem[k] = 8'h00;
            m_idx = 0;
            m_locked = 1'b1;
        end else if (io_wr) begin
            if (io_addr == 16'h0022) m_idx = int'(io_wdata);
            else if (io_addr == 16'h0023) begin
                if (m_idx == 3) m_locked = (io_wdata != 8'hC5);
                if (!m_locked) m_mem[m_idx] = io_wdata;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R7 model seg_rd", int'(seg_rd_int),
                  int'(m_mem[8'h13] & {8{m_mem[8'h14][0]}}));
            check("R8 model seg_wr", int'(seg_wr_int),
                  int'(m_mem[8'h13] & {8{m_mem[8'h14][1]}}));
            check("R9 model cache", int'(ext_cache_en), int'(m_mem[8'h18][1]));
            check("R6 model rdata", int'(io_rdata),
                  (io_rd && io_addr == 16'h0023) ? int'(m_mem[m_idx]) : 8'hFF);
        end
    end

    task automatic wr_io(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        wr_io(16'h0022, idx);
        io_addr = 16'h0023; io_rd = 1'b1;
        @(negedge clk);
        check(tag, int'(io_rdata), int'(exp));
        @(posedge clk); #1;
        io_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset seg_rd", int'(seg_rd_int), 0);
        check("R10 reset cache", int'(ext_cache_en), 0);
        @(posedge clk); #1;
        rd_reg(8'h13, 8'h00, "R10 reg13 reset");
        rd_reg(8'h14, 8'h00, "R10 reg14 reset");
        rd_reg(8'h03, 8'h00, "R10 reg03 reset");
        rd_reg(8'hA7, 8'h00, "R10 regA7 reset");

        // R2: locked after reset
        wr_io(16'h0022, 8'h13); wr_io(16'h0023, 8'hFF);
        rd_reg(8'h13, 8'h00, "R2 locked write ignored");
        check("R2 seg_rd while locked", int'(seg_rd_int), 0);

        // R4: wrong key keeps it locked
        wr_io(16'h0022, 8'h03); wr_io(16'h0023, 8'hC4);
        wr_io(16'h0022, 8'h13); wr_io(16'h0023, 8'hFF);
        rd_reg(8'h13, 8'h00, "R4 wrong key stays locked");
        rd_reg(8'h03, 8'h00, "R4 wrong key not stored");

        // R3: key unlocks and is stored
        wr_io(16'h0022, 8'h03); wr_io(16'h0023, 8'hC5);
        rd_reg(8'h03, 8'hC5, "R3 key stored");

        // R5/R7/R8/R12: shadow decode
        wr_io(16'h0022, 8'h13); wr_io(16'h0023, 8'h5A);
        wr_io(16'h0022, 8'h14); wr_io(16'h0023, 8'h01);
        check("R12 seg_rd next cycle", int'(seg_rd_int), 8'h5A);
        check("R8 no write flag", int'(seg_wr_int), 0);
        wr_io(16'h0023, 8'h02);
        check("R7 read flag off", int'(seg_rd_int), 0);
        check("R8 write flag on", int'(seg_wr_int), 8'h5A);
        wr_io(16'h0023, 8'h03);
        wr_io(16'h0022, 8'h13); wr_io(16'h0023, 8'h40);
        check("R7 firmware seg rd", int'(seg_rd_int), 8'h40);
        check("R8 firmware seg wr", int'(seg_wr_int), 8'h40);
        rd_reg(8'h13, 8'h40, "R5 reg13 readback");

        // R9: cache bit
        wr_io(16'h0022, 8'h18); wr_io(16'h0023, 8'h02);
        check("R9 cache on", int'(ext_cache_en), 1);
        wr_io(16'h0023, 8'hFD);
        check("R9 cache off", int'(ext_cache_en), 0);

        // R5: arbitrary register
        wr_io(16'h0022, 8'h77); wr_io(16'h0023, 8'h3C);
        rd_reg(8'h77, 8'h3C, "R5 reg77 readback");

        // R6: read path idles at FF
        wr_io(16'h0022, 8'h77);
        io_addr = 16'h0022; io_rd = 1'b1;
        @(negedge clk);
        check("R6 index port reads FF", int'(io_rdata), 8'hFF);
        io_addr = 16'h0023; io_rd = 1'b0;
        @(negedge clk);
        check("R6 no strobe reads FF", int'(io_rdata), 8'hFF);
        @(posedge clk); #1;

        // R1: index holds over idle cycles and reads
        io_addr = 16'h0023; io_rd = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 index held", int'(io_rdata), 8'h3C);
        @(posedge clk); #1; io_rd = 1'b0;

        // R11: stray address write ignored
        wr_io(16'h0024, 8'h99);
        wr_io(16'h0025, 8'h13);
        io_addr = 16'h0023; io_rd = 1'b1;
        @(negedge clk);
        check("R11 stray write ignored", int'(io_rdata), 8'h3C);
        @(posedge clk); #1; io_rd = 1'b0;

        // R4: relock, value not stored, later writes refused
        wr_io(16'h0022, 8'h03); wr_io(16'h0023, 8'h00);
        rd_reg(8'h03, 8'hC5, "R4 relock value not stored");
        wr_io(16'h0022, 8'h14); wr_io(16'h0023, 8'h00);
        check("R4 locked after relock", int'(seg_rd_int), 8'h40);
        rd_reg(8'h14, 8'h03, "R2 reg14 unchanged while locked");

        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule